// File: doc/BRIEF.md
# Display Pipe Timing Generator

This block produces the raster timing for one display pipe: horizontal and vertical blanking, horizontal and vertical sync, a display-enable strobe, and the running pixel and line counters. Software sets up the frame geometry through a small register file. A word address selects the register, and single-cycle write and read strobes move the data. Each window register holds two values, each stored as the real value minus one, in its two 16-bit halves. A separate configuration register starts and stops the pipe.

A run is set up in four steps. With the pipe stopped, software writes the total, blank and sync windows for both axes and the source size. It then sets the enable request. The pipe starts at the next frame start and reports that it is running through a read-only status bit. To stop the pipe, software clears the request and polls the status bit. The pipe finishes the frame it is in before the status clears. While the pipe is requested or running, the timing registers are locked. A write to them is dropped, and a sticky error flag records the attempt.

Top module: `disp_timing_gen`

## Requirements
- R1: The registers sit at word addresses 0 (horizontal total), 1 (horizontal blank), 2 (horizontal sync), 3 (vertical total), 4 (vertical blank), 5 (vertical sync), 6 (source size) and 7 (configuration). All of them reset to zero. A read strobe returns the addressed word on `reg_rdata` after the next clock edge. Addresses 8 and above read as zero, and writes to them have no effect.
- R2: While running, the pixel counter steps from 0 up to the high half of the horizontal total register and then wraps to 0. The line counter steps by one at each pixel wrap and wraps to 0 after the high half of the vertical total register.
- R3: With L the low half and H the high half of a blank register, `hblank` is high exactly when L < pixel ≤ H. `vblank` follows the same rule, using the line counter and the vertical blank register.
- R4: `hsync` and `vsync` are active high. Each is asserted when its counter lies in the same half-open window formed by its sync register, L < count ≤ H.
- R5: `de` is high only while running and only when all four conditions hold: the pixel count is at most the low half of the horizontal total register, the line count is at most the low half of the vertical total register, the pixel count is at most the source-size high half (horizontal active minus one), and the line count is at most the source-size low half (vertical active minus one).
- R6: In the configuration register, bit 31 is the enable request. Bit 30 is the read-only running status. Bit 0 is the error flag. When the request is set while the pipe is stopped, the status rises at the next clock edge and the counters start from pixel 0, line 0.
- R7: When the request is cleared while the pipe is running, the pipe keeps going until the last pixel of the last line. At that clock edge the status clears and both counters return to 0.
- R8: A write to addresses 0 through 6 while bit 31 or bit 30 is set leaves the register unchanged.
- R9: A write that R8 blocks sets the error flag, bit 0, which stays set. A configuration write with bit 0 set clears the flag.
- R10: While the pipe is stopped, both counters are 0, `hsync`, `vsync` and `de` are low, and `hblank` and `vblank` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read strobe |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| de | output | 1 | Display enable (active pixel) |
| pix_cnt | output | 16 | Current pixel within the line |
| line_cnt | output | 16 | Current line within the frame |

## Verification
The bench targets the minus-one encoding at every window edge. A design that compared with the wrong bound would widen or shift `hblank`, `hsync` or `de` by one pixel or one line, and the check that runs on every cycle of a full frame would catch it. The stop path is checked across a frame boundary: a pipe that stopped as soon as the request cleared, or one that never stopped, would show the counters dropping to zero too early or running past the last pixel. Locked writes are read back to show that the register kept its value and that the error flag was set and then cleared. A source size smaller than the active area shows whether `de` follows both limits or only one.

// File: rtl/disp_timing_gen.sv
module disp_timing_gen #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          hsync,
  output logic          vsync,
  output logic          hblank,
  output logic          vblank,
  output logic          de,
  output logic [15:0]   pix_cnt,
  output logic [15:0]   line_cnt
);
  localparam logic [AW-1:0] A_HTOT = AW'(0);
  localparam logic [AW-1:0] A_HBLK = AW'(1);
  localparam logic [AW-1:0] A_HSYN = AW'(2);
  localparam logic [AW-1:0] A_VTOT = AW'(3);
  localparam logic [AW-1:0] A_VBLK = AW'(4);
  localparam logic [AW-1:0] A_VSYN = AW'(5);
  localparam logic [AW-1:0] A_SRC  = AW'(6);
  localparam logic [AW-1:0] A_CFG  = AW'(7);

  logic [31:0] h_tot, h_blk, h_syn, v_tot, v_blk, v_syn, src_sz;
  logic        en_req, run_q, err_q;
  logic [15:0] pix_q, line_q;

  function automatic logic in_win(input logic [15:0] x, input logic [31:0] w);
    return (x > w[15:0]) && (x <= w[31:16]);
  endfunction

  wire lock      = en_req | run_q;
  wire tm_wr     = reg_wr && (reg_addr < A_CFG);
  wire cfg_wr    = reg_wr && (reg_addr == A_CFG);
  wire h_wrap    = pix_q == h_tot[31:16];
  wire frame_end = h_wrap && (line_q == v_tot[31:16]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_tot <= '0; h_blk <= '0; h_syn <= '0;
      v_tot <= '0; v_blk <= '0; v_syn <= '0;
      src_sz <= '0;
    end else if (tm_wr && !lock) begin
      case (reg_addr)
        A_HTOT:  h_tot  <= reg_wdata;
        A_HBLK:  h_blk  <= reg_wdata;
        A_HSYN:  h_syn  <= reg_wdata;
        A_VTOT:  v_tot  <= reg_wdata;
        A_VBLK:  v_blk  <= reg_wdata;
        A_VSYN:  v_syn  <= reg_wdata;
        default: src_sz <= reg_wdata;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_req <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (cfg_wr) en_req <= reg_wdata[31];
      if (tm_wr && lock) err_q <= 1'b1;
      else if (cfg_wr && reg_wdata[0]) err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pix_q  <= '0;
      line_q <= '0;
    end else if (!run_q) begin
      run_q  <= en_req;
      pix_q  <= '0;
      line_q <= '0;
    end else if (frame_end) begin
      run_q  <= en_req;
      pix_q  <= '0;
      line_q <= '0;
    end else if (h_wrap) begin
      pix_q  <= '0;
      line_q <= line_q + 16'd1;
    end else begin
      pix_q  <= pix_q + 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_rd) begin
      case (reg_addr)
        A_HTOT:  reg_rdata <= h_tot;
        A_HBLK:  reg_rdata <= h_blk;
        A_HSYN:  reg_rdata <= h_syn;
        A_VTOT:  reg_rdata <= v_tot;
        A_VBLK:  reg_rdata <= v_blk;
        A_VSYN:  reg_rdata <= v_syn;
        A_SRC:   reg_rdata <= src_sz;
        A_CFG:   reg_rdata <= {en_req, run_q, 29'd0, err_q};
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign pix_cnt  = pix_q;
  assign line_cnt = line_q;
  assign hblank   = !run_q || in_win(pix_q, h_blk);
  assign vblank   = !run_q || in_win(line_q, v_blk);
  assign hsync    = run_q && in_win(pix_q, h_syn);
  assign vsync    = run_q && in_win(line_q, v_syn);
  assign de       = run_q && (pix_q <= h_tot[15:0]) && (line_q <= v_tot[15:0])
                    && (pix_q <= src_sz[31:16]) && (line_q <= src_sz[15:0]);
endmodule

module disp_timing_gen_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic          run,
  input logic          req,
  input logic          err,
  input logic [31:0]   htot,
  input logic [31:0]   vtot,
  input logic [15:0]   pix,
  input logic [15:0]   line,
  input logic          de,
  input logic          hblank
);
  AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(req)); // R6
  AST_STOP_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run) |-> (!$past(req) && $past(pix) == $past(htot[31:16]) && $past(line) == $past(vtot[31:16]))); // R7
  AST_TIMING_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (req || run) |=> ($stable(htot) && $stable(vtot))); // R8
  AST_LOCKED_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr < AW'(7) && (req || run)) |=> err); // R9
  AST_IDLE_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (pix == 16'd0 && line == 16'd0 && !de && hblank)); // R10
  AST_PIX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pix <= htot[31:16] && line <= vtot[31:16])); // R2
endmodule

bind disp_timing_gen disp_timing_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .run(run_q), .req(en_req), .err(err_q), .htot(h_tot), .vtot(v_tot),
  .pix(pix_q), .line(line_q), .de(de), .hblank(hblank)
);

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        hsync, vsync, hblank, vblank, de;
  logic [15:0] pix_cnt, line_cnt;

  int nchk = 0, nerr = 0;
  int h_act = 8, h_tot = 16, h_bs = 8, h_be = 16, h_ss = 10, h_se = 13;
  int v_act = 4, v_tot = 8, v_bs = 4, v_be = 8, v_ss = 5, v_se = 7;
  int src_h = 8, src_v = 4;

  always #2 clk = ~clk;

  disp_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank), .de(de),
    .pix_cnt(pix_cnt), .line_cnt(line_cnt)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] pk(input int lo, input int hi);
    return {16'(hi - 1), 16'(lo - 1)};
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 4'(a);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic chk_idle(input string tag);
    chk(pix_cnt == 0 && line_cnt == 0, {tag, " R10 counters"}, {pix_cnt, line_cnt}, 0);
    chk(!hsync && !vsync && !de, {tag, " R10 sync/de"}, {hsync, vsync, de}, 0);
    chk(hblank && vblank, {tag, " R10 blanks"}, {hblank, vblank}, 3);
  endtask

  task automatic chk_outputs();
    int p = int'(pix_cnt);
    int l = int'(line_cnt);
    chk(hblank == (p >= h_bs && p < h_be), "R3 hblank", hblank, p);
    chk(vblank == (l >= v_bs && l < v_be), "R3 vblank", vblank, l);
    chk(hsync == (p >= h_ss && p < h_se), "R4 hsync", hsync, p);
    chk(vsync == (l >= v_ss && l < v_se), "R4 vsync", vsync, l);
    chk(de == (p < h_act && l < v_act && p < src_h && l < src_v), "R5 de", de, p * 100 + l);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk_idle("reset");
    for (int a = 0; a < 8; a++) begin
      rd(a, d);
      chk(d == 0, "R1 reset value", d, 0);
    end
  endtask

  task automatic t_program();
    logic [31:0] d;
    logic [31:0] vals [7];
    vals[0] = pk(h_act, h_tot); vals[1] = pk(h_bs, h_be); vals[2] = pk(h_ss, h_se);
    vals[3] = pk(v_act, v_tot); vals[4] = pk(v_bs, v_be); vals[5] = pk(v_ss, v_se);
    vals[6] = pk(src_v, src_h);
    for (int a = 0; a < 7; a++) wr(a, vals[a]);
    for (int a = 0; a < 7; a++) begin
      rd(a, d);
      chk(d == vals[a], "R1 readback", d, vals[a]);
    end
    wr(9, 32'hDEAD_BEEF);
    rd(9, d);
    chk(d == 0, "R1 unmapped address", d, 0);
    rd(7, d);
    chk(d == 0, "R1 unmapped write no side effect", d, 0);
  endtask

  task automatic t_enable();
    wr(7, 32'h8000_0000);
    chk(!de && pix_cnt == 0, "R6 not yet running", de, 0);
    @(negedge clk);
    chk(pix_cnt == 0 && line_cnt == 0 && de, "R6 start at origin", {pix_cnt, line_cnt, 7'd0, de}, 1);
  endtask

  task automatic t_frames(input int n);
    int pp = int'(pix_cnt);
    int pl = int'(line_cnt);
    chk_outputs();
    for (int i = 0; i < n * h_tot * v_tot; i++) begin
      int ep = (pp == h_tot - 1) ? 0 : pp + 1;
      int el = (pp == h_tot - 1) ? ((pl == v_tot - 1) ? 0 : pl + 1) : pl;
      @(negedge clk);
      chk(int'(pix_cnt) == ep, "R2 pixel counter", pix_cnt, ep);
      chk(int'(line_cnt) == el, "R2 line counter", line_cnt, el);
      chk_outputs();
      pp = int'(pix_cnt); pl = int'(line_cnt);
    end
  endtask

  task automatic t_status_running();
    logic [31:0] d;
    rd(7, d);
    chk(d == 32'hC000_0000, "R6 status bits", d, 32'hC000_0000);
  endtask

  task automatic t_locked_write();
    logic [31:0] d;
    wr(0, 32'h1234_5678);
    rd(0, d);
    chk(d == pk(h_act, h_tot), "R8 locked write ignored", d, pk(h_act, h_tot));
    rd(7, d);
    chk(d == 32'hC000_0001, "R9 error flag set", d, 32'hC000_0001);
    wr(7, 32'h8000_0001);
    rd(7, d);
    chk(d == 32'hC000_0000, "R9 error flag cleared", d, 32'hC000_0000);
  endtask

  task automatic t_disable();
    logic [31:0] d;
    bit seen_end = 0;
    while (!(pix_cnt == 3 && line_cnt == 1)) @(negedge clk);
    wr(7, 32'h0);
    rd(7, d);
    chk(d == 32'h4000_0000, "R7 still running after request cleared", d, 32'h4000_0000);
    for (int i = 0; i < 300 && !seen_end; i++) begin
      @(negedge clk);
      if (pix_cnt == 15 && line_cnt == 7) seen_end = 1;
    end
    chk(seen_end, "R7 frame completed", seen_end, 1);
    @(negedge clk);
    chk_idle("R7 stop at frame end");
    repeat (20) @(negedge clk);
    chk_idle("stopped hold");
    rd(7, d);
    chk(d == 0, "R7 status cleared", d, 0);
  endtask

  task automatic t_source_window();
    logic [31:0] d;
    src_h = 6; src_v = 3;
    wr(6, pk(src_v, src_h));
    rd(6, d);
    chk(d == pk(src_v, src_h), "R8 write accepted when stopped", d, pk(src_v, src_h));
    t_enable();
    t_frames(1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_enable();
    t_frames(2);
    t_status_running();
    t_locked_write();
    t_disable();
    t_source_window();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end

  initial begin
    #400000;
    nchk++; nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nerr);
    $finish;
  end
endmodule